// File: doc/BRIEF.md
# Inter-Stream Delay Buffer

This block sits between two copies of one program running on two cores. The leading copy runs a reduced instruction stream. The trailing copy runs the full stream and checks it. The leading side pushes records into the buffer and the trailing side pops them in the same order.

A record is one of two kinds, selected by a one-bit tag:
- A control record holds a trace identifier and a bit vector that marks which instructions were removed.
- A data record holds a register name, a value and a memory address.

When the leading context turns out to be wrong, recovery starts with a flush. The flush drops every queued record in one cycle. Recovery then uses a copy mode: the block walks the register index space of the trailing core's register file. It reads one entry per cycle through a small read port and pushes each entry into the queue as a data record. While the copy runs, the producer cannot enqueue.

The storage is a simple dual-port memory that block RAM can hold. A registered head stage sits in front of it, so every output pin comes from a flop.

Top module: `stream_delay_queue`

## Requirements
- R1: Records leave in the order in which they were accepted. The tag and the fields of the active kind are unchanged.
- R2: The tag value 0 marks a control record, which carries a trace id and a removal vector. The tag value 1 marks a data record, which carries a register name, a value and an address. At the output, the fields of the other kind read as zero, whatever was driven with that record at the input.
- R3: `in_ready` is low while DEPTH records are held. A record offered while `in_ready` is low is not stored.
- R4: `out_valid` is low while the queue is empty. `out_ready` has no effect while `out_valid` is low.
- R5: A record accepted into an empty queue makes `out_valid` high one cycle after the accepting edge.
- R6: A flush leaves the queue empty on the next cycle and discards any enqueue or dequeue in the same cycle. None of the earlier records reappears after the flush.
- R7: `rf_copy_start` in the idle state raises `rf_copy_busy` on the next cycle and starts a copy.
  - The copy presents `rf_rd_idx` = 0, 1, …, NREGS-1 in order.
  - In each cycle that has space, it pushes the data record {name = index, value = `rf_rd_data`, address = 0} and steps the index.
  - It stays on the same index while the queue is full.
  - `in_ready` is low for the whole copy.
  - `rf_copy_busy` falls after the last index is pushed.
- R8: A flush aborts a running copy. `rf_copy_start` is ignored while a copy is running and in a cycle that carries a flush.
- R9: After reset, `out_valid` = 0, `in_ready` = 1 and `rf_copy_busy` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the queue and abort any copy |
| in_valid | input | 1 | Producer offers a record |
| in_ready | output | 1 | Queue accepts a producer record |
| in_kind | input | 1 | Record tag: 0 control, 1 data |
| in_trace | input | TRACE_W | Trace id (control) |
| in_rmv | input | RMV_W | Removal vector (control) |
| in_rname | input | RNAME_W | Register name (data) |
| in_val | input | VAL_W | Register value (data) |
| in_addr | input | ADR_W | Load/store address (data) |
| out_valid | output | 1 | Head record is present |
| out_ready | input | 1 | Consumer takes the head record |
| out_kind | output | 1 | Head tag |
| out_trace | output | TRACE_W | Head trace id, zero for data records |
| out_rmv | output | RMV_W | Head removal vector, zero for data records |
| out_rname | output | RNAME_W | Head register name, zero for control records |
| out_val | output | VAL_W | Head value, zero for control records |
| out_addr | output | ADR_W | Head address, zero for control records |
| rf_copy_start | input | 1 | Start a register-file copy |
| rf_copy_busy | output | 1 | Copy in progress |
| rf_rd_idx | output | RNAME_W | Register index being read by the copy |
| rf_rd_data | input | VAL_W | Register value for `rf_rd_idx`, same cycle |

## Verification
The hardest case to reach from the ports is a copy that stalls on a full queue while the consumer pops at random. In that case the write pointer, the copy index and the bypass from write to head all move in the same cycles.

The bench reaches it directly. It starts a copy with the consumer held off, so the 32-entry register walk meets a 16-entry queue. It then releases the consumer with a random ready pattern while the producer keeps offering records that must be refused.

Flushes and restart requests are dropped into running copies, including a start in the same cycle as a flush.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

  typedef enum logic {
    REC_CTRL = 1'b0,
    REC_DATA = 1'b1
  } rec_kind_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdq_ptrs.sv
// Pointer, occupancy and flag control. DEPTH must be a power of two.
module sdq_ptrs #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             copy_busy_nx,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_addr_nx,
  output logic             out_valid,
  output logic             in_ready,
  output logic             has_space
);

  logic [PTR_W-1:0] rd_ptr, wr_ptr_nx, rd_ptr_nx;
  logic [CNT_W-1:0] count, count_nx;

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    count_nx  = count;
    if (flush) begin
      wr_ptr_nx = '0;
      rd_ptr_nx = '0;
      count_nx  = '0;
    end else begin
      if (wr_en) wr_ptr_nx = wr_ptr + 1'b1;
      if (rd_en) rd_ptr_nx = rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count_nx = count + 1'b1;
        2'b01:   count_nx = count - 1'b1;
        default: count_nx = count;
      endcase
    end
  end

  assign rd_addr_nx = rd_ptr_nx;
  assign has_space  = (count != CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      out_valid <= 1'b0;
      in_ready  <= 1'b1;
    end else begin
      wr_ptr    <= wr_ptr_nx;
      rd_ptr    <= rd_ptr_nx;
      count     <= count_nx;
      out_valid <= (count_nx != '0);
      in_ready  <= (count_nx != CNT_W'(DEPTH)) && !copy_busy_nx;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |-> has_space);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !flush) |-> (count != '0));

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!out_valid && count == '0));

  assert_first_visible_R5: assert property (@(posedge clk) disable iff (rst)
    (!flush && count == '0 && wr_en) |=> out_valid);

endmodule

// File: rtl/sdq_store.sv
// Simple dual-port storage with a registered head; a write to the slot
// being read in the same cycle is forwarded.
module sdq_store #(
  parameter int WIDTH = 70,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (we && waddr == raddr) q <= wdata;
    else                      q <= mem[raddr];
  end

endmodule

// File: rtl/sdq_rfcopy.sv
// Register-file walk used in recovery: one register per cycle with space.
module sdq_rfcopy #(
  parameter int NREGS = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             start,
  input  logic             has_space,
  output logic             busy,
  output logic             busy_nx,
  output logic [IDX_W-1:0] idx,
  output logic             push
);

  logic [IDX_W-1:0] idx_nx;
  logic             last;

  assign last = (idx == IDX_W'(NREGS - 1));
  assign push = busy && has_space && !flush;

  always_comb begin
    busy_nx = busy;
    idx_nx  = idx;
    if (flush) begin
      busy_nx = 1'b0;
      idx_nx  = '0;
    end else if (!busy) begin
      if (start) begin
        busy_nx = 1'b1;
        idx_nx  = '0;
      end
    end else if (push) begin
      if (last) begin
        busy_nx = 1'b0;
        idx_nx  = '0;
      end else begin
        idx_nx = idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else begin
      busy <= busy_nx;
      idx  <= idx_nx;
    end
  end

  assert_copy_flush_abort_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !busy);

  assert_copy_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !flush && !push) |=> (busy && idx == $past(idx)));

  assert_copy_holds_when_full_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !has_space && !flush) |=> (busy && $stable(idx)));

endmodule

// File: rtl/stream_delay_queue.sv
module stream_delay_queue
  import sdq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TRACE_W = 8,
  parameter int RMV_W   = 16,
  parameter int RNAME_W = 5,
  parameter int VAL_W   = 32,
  parameter int ADR_W   = 32,
  parameter int NREGS   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_kind,
  input  logic [TRACE_W-1:0] in_trace,
  input  logic [RMV_W-1:0]   in_rmv,
  input  logic [RNAME_W-1:0] in_rname,
  input  logic [VAL_W-1:0]   in_val,
  input  logic [ADR_W-1:0]   in_addr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_kind,
  output logic [TRACE_W-1:0] out_trace,
  output logic [RMV_W-1:0]   out_rmv,
  output logic [RNAME_W-1:0] out_rname,
  output logic [VAL_W-1:0]   out_val,
  output logic [ADR_W-1:0]   out_addr,
  input  logic               rf_copy_start,
  output logic               rf_copy_busy,
  output logic [RNAME_W-1:0] rf_rd_idx,
  input  logic [VAL_W-1:0]   rf_rd_data
);

  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CTRL_W = TRACE_W + RMV_W;
  localparam int DREC_W = RNAME_W + VAL_W + ADR_W;
  localparam int PAY_W  = max2(CTRL_W, DREC_W);
  localparam int WORD_W = PAY_W + 1;

  logic               prod_push, cp_push, wr_en, rd_en, has_space, cp_busy_nx;
  logic [PTR_W-1:0]   wr_ptr, rd_addr_nx;
  logic [RNAME_W-1:0] cp_idx;
  logic [PAY_W-1:0]   pay;
  rec_kind_e          wkind, hkind;
  logic [WORD_W-1:0]  wdata, head;

  assign prod_push = in_valid && in_ready;
  assign wr_en     = prod_push || cp_push;
  assign rd_en     = out_valid && out_ready;

  sdq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en), .rd_en(rd_en),
    .copy_busy_nx(cp_busy_nx), .wr_ptr(wr_ptr), .rd_addr_nx(rd_addr_nx),
    .out_valid(out_valid), .in_ready(in_ready), .has_space(has_space)
  );

  sdq_rfcopy #(.NREGS(NREGS), .IDX_W(RNAME_W)) u_copy (
    .clk(clk), .rst(rst), .flush(flush), .start(rf_copy_start),
    .has_space(has_space), .busy(rf_copy_busy), .busy_nx(cp_busy_nx),
    .idx(cp_idx), .push(cp_push)
  );

  assign rf_rd_idx = cp_idx;

  always_comb begin
    pay = '0;
    if (cp_push) begin
      wkind = REC_DATA;
      pay[DREC_W-1:0] = {cp_idx, rf_rd_data, {ADR_W{1'b0}}};
    end else if (in_kind) begin
      wkind = REC_DATA;
      pay[DREC_W-1:0] = {in_rname, in_val, in_addr};
    end else begin
      wkind = REC_CTRL;
      pay[CTRL_W-1:0] = {in_trace, in_rmv};
    end
    wdata = {wkind, pay};
  end

  sdq_store #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_en && !flush), .waddr(wr_ptr), .wdata(wdata),
    .raddr(rd_addr_nx), .q(head)
  );

  assign hkind    = rec_kind_e'(head[PAY_W]);
  assign out_kind = head[PAY_W];

  always_comb begin
    out_trace = '0;
    out_rmv   = '0;
    out_rname = '0;
    out_val   = '0;
    out_addr  = '0;
    if (hkind == REC_DATA) begin
      {out_rname, out_val, out_addr} = head[DREC_W-1:0];
    end else begin
      {out_trace, out_rmv} = head[CTRL_W-1:0];
    end
  end

  assert_copy_blocks_producer_R7: assert property (@(posedge clk) disable iff (rst)
    rf_copy_busy |-> !in_ready);

  assert_single_writer_R7: assert property (@(posedge clk) disable iff (rst)
    !(prod_push && cp_push));

endmodule

// File: tb/stream_delay_queue_test.sv
module stream_delay_queue_test;

  localparam int DEPTH = 16;
  localparam int NREGS = 32;

  typedef struct packed {
    logic        kind;
    logic [7:0]  tr;
    logic [15:0] rv;
    logic [4:0]  rn;
    logic [31:0] v;
    logic [31:0] a;
  } rec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0, in_valid = 1'b0, in_kind = 1'b0, out_ready = 1'b0, rf_copy_start = 1'b0;
  logic [7:0]  in_trace = '0;
  logic [15:0] in_rmv = '0;
  logic [4:0]  in_rname = '0;
  logic [31:0] in_val = '0, in_addr = '0;
  logic in_ready, out_valid, out_kind, rf_copy_busy;
  logic [7:0]  out_trace;
  logic [15:0] out_rmv;
  logic [4:0]  out_rname, rf_rd_idx;
  logic [31:0] out_val, out_addr, rf_rd_data;

  always #10 clk = ~clk;

  function automatic logic [31:0] rf_val(input logic [4:0] i);
    return 32'hC0DE_0000 ^ ({27'd0, i} * 32'h0101_0203);
  endfunction

  assign rf_rd_data = rf_val(rf_rd_idx);

  stream_delay_queue #(.DEPTH(DEPTH), .NREGS(NREGS)) uut (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_trace(in_trace), .in_rmv(in_rmv), .in_rname(in_rname),
    .in_val(in_val), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_trace(out_trace), .out_rmv(out_rmv), .out_rname(out_rname),
    .out_val(out_val), .out_addr(out_addr),
    .rf_copy_start(rf_copy_start), .rf_copy_busy(rf_copy_busy),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data)
  );

  int   vectors = 0, misses = 0;
  rec_t model[$];
  bit   cp_busy = 1'b0;
  int   cp_idx = 0;
  bit   last_flush = 1'b0, just_first = 1'b0;
  string busy_tag = "R7";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic rec_t mask(input rec_t r);
    rec_t m = r;
    if (r.kind) begin m.tr = '0; m.rv = '0; end
    else begin m.rn = '0; m.v = '0; m.a = '0; end
    return m;
  endfunction

  function automatic rec_t rand_rec();
    rec_t r;
    r.kind = 1'($urandom);
    r.tr = 8'($urandom);
    r.rv = 16'($urandom);
    r.rn = 5'($urandom);
    r.v  = $urandom;
    r.a  = $urandom;
    return r;
  endfunction

  function automatic bit exp_ready();
    return (model.size() != DEPTH) && !cp_busy;
  endfunction

  task automatic check_now();
    bit   ov = (model.size() != 0);
    rec_t got;
    string vt = last_flush ? "R6" : (just_first ? "R5" : "R4");
    chk(out_valid == ov, vt, "out_valid", out_valid, ov);
    chk(in_ready == exp_ready(), "R3", "in_ready", in_ready, exp_ready());
    chk(rf_copy_busy == cp_busy, busy_tag, "rf_copy_busy", rf_copy_busy, cp_busy);
    if (cp_busy) chk(rf_rd_idx == 5'(cp_idx), busy_tag, "rf_rd_idx", rf_rd_idx, cp_idx);
    if (ov && out_valid) begin
      got = '{out_kind, out_trace, out_rmv, out_rname, out_val, out_addr};
      chk(got == model[0], "R1", "head record", got, model[0]);
      if (out_kind) chk({out_trace, out_rmv} == '0, "R2", "control fields of data rec",
                        {out_trace, out_rmv}, 0);
      else chk({out_rname, out_val, out_addr} == '0, "R2", "data fields of control rec",
               {out_rname, out_val, out_addr}, 0);
    end
  endtask

  // One cycle: check at negedge, drive, update model, wait for next negedge.
  task automatic step(input bit iv, input rec_t r, input bit ordy, input bit fl, input bit st);
    bit ov  = (model.size() != 0);
    bit ir  = exp_ready();
    int sz0 = model.size();
    bit pop, push, cpp;
    check_now();
    in_valid = iv; in_kind = r.kind; in_trace = r.tr; in_rmv = r.rv;
    in_rname = r.rn; in_val = r.v; in_addr = r.a;
    out_ready = ordy; flush = fl; rf_copy_start = st;
    pop  = ov && ordy;
    push = iv && ir;
    just_first = 1'b0;
    if (fl) begin
      model.delete();
      cp_busy = 1'b0;
      cp_idx  = 0;
    end else begin
      cpp = cp_busy && (sz0 != DEPTH);
      if (pop) void'(model.pop_front());
      if (push) model.push_back(mask(r));
      if (cp_busy) begin
        if (cpp) begin
          model.push_back('{1'b1, 8'd0, 16'd0, 5'(cp_idx), rf_val(5'(cp_idx)), 32'd0});
          if (cp_idx == NREGS - 1) begin cp_busy = 1'b0; cp_idx = 0; end
          else cp_idx++;
        end
      end else if (st) begin
        cp_busy = 1'b1;
        cp_idx  = 0;
      end
      just_first = (push || cpp) && sz0 == 0;
    end
    last_flush = fl;
    @(negedge clk);
  endtask

  task automatic idle(input bit ordy);
    step(1'b0, '0, ordy, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired (all requirements): actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset values
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
    chk(rf_copy_busy == 1'b0, "R9", "rf_copy_busy after reset", rf_copy_busy, 0);

    // R5: single record into empty queue; R4: pop on empty is ignored
    idle(1'b1);
    step(1'b1, '{1'b0, 8'h5A, 16'hBEEF, 5'd3, 32'h1234, 32'h9}, 1'b0, 1'b0, 1'b0);
    idle(1'b0);
    idle(1'b1);
    repeat (3) idle(1'b1);

    // R3: fill beyond DEPTH with consumer stalled, extra offers refused
    for (int i = 0; i < DEPTH + 6; i++) step(1'b1, rand_rec(), 1'b0, 1'b0, 1'b0);
    // drain completely and past empty (R4)
    for (int i = 0; i < DEPTH + 4; i++) idle(1'b1);

    // random mixed traffic
    for (int i = 0; i < 2000; i++)
      step(($urandom % 10) < 6, rand_rec(), ($urandom % 10) < 6,
           ($urandom % 100) == 0, 1'b0);

    // R7: copy against a stalled consumer, then random drain with refused offers
    while (model.size() != 0) idle(1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < DEPTH + 8; i++) step(1'b1, rand_rec(), 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 200; i++) step(1'b1, rand_rec(), ($urandom % 3) == 0, 1'b0, 1'b0);
    while (model.size() != 0) idle(1'b1);

    // R8: restart ignored while busy, flush aborts, start with flush ignored
    busy_tag = "R8";
    step(1'b0, '0, 1'b1, 1'b0, 1'b1);
    repeat (5) idle(1'b1);
    step(1'b0, '0, 1'b1, 1'b0, 1'b1);
    repeat (4) idle(1'b1);
    step(1'b0, '0, 1'b0, 1'b1, 1'b1);
    repeat (3) idle(1'b1);
    step(1'b0, '0, 1'b0, 1'b1, 1'b1);
    repeat (3) idle(1'b1);
    busy_tag = "R7";

    // R6: flush with simultaneous push and pop on a loaded queue
    for (int i = 0; i < 6; i++) step(1'b1, rand_rec(), 1'b0, 1'b0, 1'b0);
    step(1'b1, rand_rec(), 1'b1, 1'b1, 1'b0);
    idle(1'b1);
    step(1'b1, rand_rec(), 1'b0, 1'b0, 1'b0);
    repeat (3) idle(1'b1);

    // random traffic with copies and flushes
    for (int i = 0; i < 3000; i++)
      step(($urandom % 10) < 5, rand_rec(), ($urandom % 10) < 5,
           ($urandom % 150) == 0, ($urandom % 60) == 0);
    repeat (60) idle(1'b1);
    check_now();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule